// File: doc/BRIEF.md
# Dual-Width Flash Access Bridge

This block is a slave on a 32-bit processor bus that fronts an external parallel flash device of 16 Mbit. Every bus transfer carries 32 data bits. A one-bit mode register selects how the flash is read. In word mode the whole 32-bit value from the flash is returned. In byte mode only the low eight bits come from the flash and the rest read as zero. The block decodes two fixed regions of the global map: a flash window and the mode register. It drives the flash chip-enable, output-enable and write-enable lines, the address, and the write data. It also tells the device which width to present.

A flash access holds its strobes for one base cycle plus a parameterised number of wait states and then raises ready for one cycle. The default of 15 wait states suits the slow processor. A lighter processor needs only 7. Writes reach the flash only in byte mode. A write to the flash window in word mode completes on the bus but produces no strobe. The master issues one request at a time. A new request may be presented in the same cycle that ready returns, so accesses can run back to back.

Top module: `flash_width_bridge`

## Requirements
- R1: After reset the mode register holds 0 (byte mode), `flWide` is low, all flash strobes are high and `busReady` is low. A read of the mode register returns the mode in bit 0, and bits [31:1] always read as 0.
- R2: A write to the mode register address (default 0xFC000000) loads `busWdata[0]` into the mode, with 1 meaning word mode and 0 meaning byte mode. `flWide` equals the mode.
- R3: A byte-mode flash read returns `{24'h0, flDataIn[7:0]}`, whatever the device drives on bits [31:8].
- R4: A word-mode flash read returns all 32 bits of `flDataIn`.
- R5: A write to the flash window in word mode asserts none of `flCeN`, `flOeN`, `flWeN` or `flDataOe`, leaves the mode unchanged, and gets `busReady` in the cycle after the request.
- R6: A byte-mode flash write holds `flWeN` and `flCeN` low, with `flDataOe` high and `flDataOut = {24'h0, busWdata[7:0]}`, for WAIT_STATES+1 cycles. `flOeN` stays high throughout.
- R7: For a flash read or an accepted flash write, the strobes go low in the cycle after the request and stay low for exactly WAIT_STATES+1 cycles. `busReady` is then high for one cycle, WAIT_STATES+2 cycles after the request, while the strobes are already high. Read and write strobes are never low together.
- R8: A request to the mode register, or to any address outside both regions, makes no flash strobe and gets `busReady` in the next cycle. A read outside both regions returns 0.
- R9: The flash window is every address whose bits [31:WIN_LSB] equal those of FLASH_BASE (default 0xF8000000, WIN_LSB 24). `flAddr` is `busAddr[FLASH_ADDR_W-1:0]` of the request. The mode register matches only its exact address.
- R10: A request is taken only when the block is idle or in its ready cycle. A request in the ready cycle of a mode write is decoded with the new mode. A request raised while a flash access is in progress is dropped and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busReq | input | 1 | One-cycle request strobe |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 32 | Global byte-address of the transfer |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busReady is high |
| busReady | output | 1 | One-cycle completion pulse |
| flAddr | output | FLASH_ADDR_W | Flash address |
| flCeN | output | 1 | Flash chip enable, active low |
| flOeN | output | 1 | Flash output enable, active low |
| flWeN | output | 1 | Flash write enable, active low |
| flWide | output | 1 | 1 selects 32-bit device width |
| flDataOut | output | 32 | Write data toward the flash |
| flDataOe | output | 1 | Drive enable for flDataOut |
| flDataIn | input | 32 | Data from the flash |

## Verification
Two things can fall in the same cycle: the ready cycle of a mode-register write and the acceptance of the next request. The width gate for a flash write is then decided in the very cycle the new mode takes effect. The bench provokes this by setting word mode and raising a flash write in the ready cycle of that mode write. It judges the result by the absence of any chip-enable or write-enable cycle at the behavioural flash stub, and by a ready pulse one cycle later. A second case raises a mode write while a flash read is still holding its strobes. A mode readback afterwards shows that the mode was not disturbed.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_DONE = 2'd2
  } fwbState_t;

  // Strobes from the control sequencer to the datapath
  typedef struct packed {
    logic load;      // request accepted: latch address and write byte
    logic readMode;  // accepted read of the mode register
    logic setMode;   // accepted write of the mode register
    logic capFlash;  // last wait cycle of a flash read: capture data
  } fwbStrobe_t;

endpackage

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int WAIT_STATES = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReq,
  input  logic       busWrite,
  input  logic       flashHit,
  input  logic       modeHit,
  input  logic       wordMode,
  output fwbStrobe_t strb,
  output logic       busReady,
  output logic       flCeN,
  output logic       flOeN,
  output logic       flWeN,
  output logic       flDataOe
);

  localparam int CNT_W = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_STATES);
  localparam logic [CNT_W:0] RUN_LEN = (CNT_W + 1)'(WAIT_STATES + 1);

  fwbState_t state, stateNxt;
  logic [CNT_W-1:0] cnt;
  logic isWr;
  logic accept, goFlash, lastWait, inAcc;

  assign inAcc    = (state == ST_ACC);
  assign accept   = busReq && ((state == ST_IDLE) || (state == ST_DONE));
  assign goFlash  = flashHit && !(busWrite && wordMode);
  assign lastWait = inAcc && (cnt == CNT_LAST);

  always_comb begin
    stateNxt = state;
    if (accept) begin
      stateNxt = goFlash ? ST_ACC : ST_DONE;
    end else begin
      case (state)
        ST_ACC:  stateNxt = lastWait ? ST_DONE : ST_ACC;
        ST_DONE: stateNxt = ST_IDLE;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) begin
        cnt  <= '0;
        isWr <= busWrite;
      end else if (inAcc && !lastWait) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load     = accept;
    strb.readMode = accept && modeHit && !busWrite;
    strb.setMode  = accept && modeHit && busWrite;
    strb.capFlash = lastWait && !isWr;
  end

  assign busReady = (state == ST_DONE);
  assign flCeN    = !inAcc;
  assign flOeN    = !(inAcc && !isWr);
  assign flWeN    = !(inAcc && isWr);
  assign flDataOe = inAcc && isWr;

  // Checker: length of each chip-enable run
  logic [CNT_W:0] ceRun;
  always_ff @(posedge clk) begin
    if (!rstN)       ceRun <= '0;
    else if (!flCeN) ceRun <= ceRun + 1'b1;
    else             ceRun <= '0;
  end

  AST_CE_RUN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flCeN) |-> (ceRun == RUN_LEN)); // R7

  AST_READY_AFTER_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flCeN) |-> busReady); // R7

  AST_NO_WORD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> !wordMode); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!flOeN && !flWeN)); // R7

  AST_WE_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> (flDataOe && !flCeN)); // R6

endmodule

// File: rtl/fwb_dpath.sv
module fwb_dpath
  import fwb_pkg::*;
#(
  parameter logic [31:0] FLASH_BASE   = 32'hF800_0000,
  parameter logic [31:0] MODE_ADDR    = 32'hFC00_0000,
  parameter int          WIN_LSB      = 24,
  parameter int          FLASH_ADDR_W = 21
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fwbStrobe_t              strb,
  input  logic [31:0]             busAddr,
  input  logic [31:0]             busWdata,
  input  logic [31:0]             flDataIn,
  output logic                    flashHit,
  output logic                    modeHit,
  output logic                    wordMode,
  output logic [31:0]             busRdata,
  output logic [FLASH_ADDR_W-1:0] flAddr,
  output logic [31:0]             flDataOut
);

  logic        modeBit;
  logic [7:0]  wrByte;
  logic [31:0] rdataQ;
  logic [FLASH_ADDR_W-1:0] addrQ;
  logic        unusedWdata;

  assign unusedWdata = ^busWdata[31:8];
  assign flashHit = (busAddr[31:WIN_LSB] == FLASH_BASE[31:WIN_LSB]);
  assign modeHit  = (busAddr == MODE_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeBit <= 1'b0;
      wrByte  <= '0;
      rdataQ  <= '0;
      addrQ   <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= busAddr[FLASH_ADDR_W-1:0];
        wrByte <= busWdata[7:0];
        rdataQ <= strb.readMode ? {31'h0, modeBit} : 32'h0;
      end
      if (strb.setMode) modeBit <= busWdata[0];
      if (strb.capFlash) begin
        rdataQ <= modeBit ? flDataIn : {24'h0, flDataIn[7:0]};
      end
    end
  end

  assign wordMode  = modeBit;
  assign busRdata  = rdataQ;
  assign flAddr    = addrQ;
  assign flDataOut = {24'h0, wrByte};

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.capFlash) && !modeBit) |-> (rdataQ[31:8] == 24'h0)); // R3

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.setMode |=> $stable(modeBit)); // R10

  AST_MODE_READ_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    strb.readMode |=> (rdataQ[31:1] == 31'h0)); // R1

endmodule

// File: rtl/flash_width_bridge.sv
module flash_width_bridge
  import fwb_pkg::*;
#(
  parameter int          WAIT_STATES  = 15,
  parameter logic [31:0] FLASH_BASE   = 32'hF800_0000,
  parameter logic [31:0] MODE_ADDR    = 32'hFC00_0000,
  parameter int          WIN_LSB      = 24,
  parameter int          FLASH_ADDR_W = 21
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busReq,
  input  logic                    busWrite,
  input  logic [31:0]             busAddr,
  input  logic [31:0]             busWdata,
  output logic [31:0]             busRdata,
  output logic                    busReady,
  output logic [FLASH_ADDR_W-1:0] flAddr,
  output logic                    flCeN,
  output logic                    flOeN,
  output logic                    flWeN,
  output logic                    flWide,
  output logic [31:0]             flDataOut,
  output logic                    flDataOe,
  input  logic [31:0]             flDataIn
);

  fwbStrobe_t strb;
  logic flashHit, modeHit, wordMode;

  fwb_ctrl #(.WAIT_STATES(WAIT_STATES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busReq   (busReq),
    .busWrite (busWrite),
    .flashHit (flashHit),
    .modeHit  (modeHit),
    .wordMode (wordMode),
    .strb     (strb),
    .busReady (busReady),
    .flCeN    (flCeN),
    .flOeN    (flOeN),
    .flWeN    (flWeN),
    .flDataOe (flDataOe)
  );

  fwb_dpath #(
    .FLASH_BASE   (FLASH_BASE),
    .MODE_ADDR    (MODE_ADDR),
    .WIN_LSB      (WIN_LSB),
    .FLASH_ADDR_W (FLASH_ADDR_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .flDataIn  (flDataIn),
    .flashHit  (flashHit),
    .modeHit   (modeHit),
    .wordMode  (wordMode),
    .busRdata  (busRdata),
    .flAddr    (flAddr),
    .flDataOut (flDataOut)
  );

  assign flWide = wordMode;

endmodule

// File: tb/flash_width_bridge_tb_top.sv
module flash_width_bridge_tb_top;

  localparam int WAITS  = 15;
  localparam int FL_LAT = WAITS + 2;
  localparam logic [31:0] MODE_A = 32'hFC00_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0, busWrite = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [31:0] busRdata, flDataOut, flDataIn;
  logic busReady, flCeN, flOeN, flWeN, flWide, flDataOe;
  logic [20:0] flAddr;

  always #2 clk = ~clk;

  flash_width_bridge dut_i (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .flAddr(flAddr), .flCeN(flCeN), .flOeN(flOeN),
    .flWeN(flWeN), .flWide(flWide), .flDataOut(flDataOut),
    .flDataOe(flDataOe), .flDataIn(flDataIn)
  );

  int checks = 0;
  int errors = 0;
  int cycCnt = 0;
  bit finished = 0;

  always @(posedge clk) cycCnt++;

  function automatic logic [31:0] flashWord(input logic [20:0] a);
    return ({11'h0, a} * 32'h9E37_79B1) + 32'h0123_4567;
  endfunction

  // Behavioural flash stub: upper lanes carry junk in byte width
  always_comb begin
    if (!flCeN && !flOeN)
      flDataIn = flWide ? flashWord(flAddr) : {24'hC3C3C3, flashWord(flAddr)[7:0]};
    else
      flDataIn = 32'hFFFF_FFFF;
  end

  int weRun = 0, lastPulse = 0, wrCount = 0, ceTotal = 0, oeBadOnWrite = 0;
  logic [31:0] lastWrData = '0;
  logic [20:0] lastWrAddr = '0;

  always @(negedge clk) begin
    if (!flCeN) ceTotal++;
    if (!flCeN && !flWeN) begin
      weRun++;
      lastWrData = flDataOut;
      lastWrAddr = flAddr;
      if (!flDataOe || !flOeN) oeBadOnWrite++;
    end else if (weRun != 0) begin
      lastPulse = weRun;
      weRun = 0;
      wrCount++;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] expData;
    int          expLat;
    int          issueCyc;
    string       rq;
  } item_t;
  item_t expQ[$];

  // Monitor: compare each completion against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && busReady) begin
        if (expQ.size() == 0) begin
          chk(0, "R10", "unexpected ready", 32'h1, 32'h0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          chk(busRdata == it.expData, it.rq, "read data", busRdata, it.expData);
          chk((cycCnt - it.issueCyc) == it.expLat, it.rq, "ready latency",
              32'(cycCnt - it.issueCyc), 32'(it.expLat));
        end
      end
    end
  end

  // Driver: starts at a negedge, returns at the negedge where ready is seen
  task automatic doReq(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                       input logic [31:0] expD, input int expLat, input string rq);
    item_t it;
    busWrite = wr; busAddr = addr; busWdata = wd; busReq = 1'b1;
    it.expData = expD; it.expLat = expLat; it.issueCyc = cycCnt; it.rq = rq;
    expQ.push_back(it);
    @(negedge clk);
    busReq = 1'b0;
    while (!busReady) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(flCeN && flOeN && flWeN, "R1", "strobes idle in reset", {29'h0, flCeN, flOeN, flWeN}, 32'h7);
    chk(!busReady && !flWide && !flDataOe, "R1", "ready/wide/oe low in reset",
        {29'h0, busReady, flWide, flDataOe}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(flWide == 1'b0, "R1", "byte mode after reset", {31'h0, flWide}, 32'h0);

    doReq(1'b0, MODE_A, 32'h0, 32'h0, 1, "R1");

    // R3/R7/R9: byte reads, low and top of the flash range
    doReq(1'b0, 32'hF800_0123, 32'h0, {24'h0, flashWord(21'h123)[7:0]}, FL_LAT, "R3");
    doReq(1'b0, 32'hF81F_FFFF, 32'h0, {24'h0, flashWord(21'h1F_FFFF)[7:0]}, FL_LAT, "R9");
    doReq(1'b0, 32'hF8E0_0007, 32'h0, {24'h0, flashWord(21'h7)[7:0]}, FL_LAT, "R9");

    // R6: byte write
    doReq(1'b1, 32'hF800_0040, 32'hDEAD_BE5A, 32'h0, FL_LAT, "R6");
    #1;
    chk(wrCount == 1, "R6", "one write pulse", 32'(wrCount), 32'd1);
    chk(lastPulse == WAITS + 1, "R6", "WE pulse length", 32'(lastPulse), 32'(WAITS + 1));
    chk(lastWrData == 32'h0000_005A, "R6", "flash write data", lastWrData, 32'h5A);
    chk(lastWrAddr == 21'h40, "R9", "flash write address", {11'h0, lastWrAddr}, 32'h40);
    chk(oeBadOnWrite == 0, "R6", "OE high and data driven", 32'(oeBadOnWrite), 32'h0);

    // R8: outside both regions, and a near-miss of the mode register
    begin
      int ceBefore;
      ceBefore = ceTotal;
      doReq(1'b0, 32'hF900_0000, 32'h0, 32'h0, 1, "R8");
      doReq(1'b0, 32'hFC00_0004, 32'h0, 32'h0, 1, "R9");
      #1;
      chk(ceTotal == ceBefore, "R8", "no CE outside regions", 32'(ceTotal), 32'(ceBefore));
    end

    // R2/R5/R10: set word mode, then flash write in the same ready cycle
    begin
      int ceBefore, wrBefore;
      ceBefore = ceTotal; wrBefore = wrCount;
      doReq(1'b1, MODE_A, 32'h0000_0001, 32'h0, 1, "R2");
      chk(flWide == 1'b1, "R2", "width pin follows mode", {31'h0, flWide}, 32'h1);
      doReq(1'b1, 32'hF800_0080, 32'h1234_5678, 32'h0, 1, "R5");
      #1;
      chk(wrCount == wrBefore, "R5", "no write pulse in word mode", 32'(wrCount), 32'(wrBefore));
      chk(ceTotal == ceBefore, "R10", "no CE on blocked write", 32'(ceTotal), 32'(ceBefore));
    end
    doReq(1'b0, MODE_A, 32'h0, 32'h1, 1, "R1");

    // R4: word read
    doReq(1'b0, 32'hF800_0200, 32'h0, flashWord(21'h200), FL_LAT, "R4");

    // R10: mode write raised mid-access is dropped
    begin
      item_t it;
      busWrite = 1'b0; busAddr = 32'hF800_0300; busReq = 1'b1;
      it.expData = flashWord(21'h300); it.expLat = FL_LAT; it.issueCyc = cycCnt; it.rq = "R10";
      expQ.push_back(it);
      @(negedge clk);
      busWrite = 1'b1; busAddr = MODE_A; busWdata = 32'h0;
      @(negedge clk);
      busReq = 1'b0;
      while (!busReady) @(negedge clk);
    end
    doReq(1'b0, MODE_A, 32'h0, 32'h1, 1, "R10");

    // R1/R2: only bit 0 is stored; back to byte mode
    doReq(1'b1, MODE_A, 32'hFFFF_FFFE, 32'h0, 1, "R2");
    doReq(1'b0, MODE_A, 32'h0, 32'h0, 1, "R1");
    chk(flWide == 1'b0, "R2", "width pin back to byte", {31'h0, flWide}, 32'h0);
    doReq(1'b0, 32'hF800_0200, 32'h0, {24'h0, flashWord(21'h200)[7:0]}, FL_LAT, "R3");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R7", "all requests completed", 32'(expQ.size()), 32'h0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule